// File: doc/BRIEF.md
# Scan Test Application Sequencer

This block runs the manufacturing test of a small full-scan circuit on its own. It contains the circuit under test and the controller that exercises it. The circuit is a set of scan flip-flops around a stand-in combinational network. The flip-flops are dealt round-robin into a parameterised number of serial chains: flip-flop g sits in chain g mod NCHAIN, at position g div NCHAIN, and position 0 is the scan-in end. A single capture-enable line puts every flip-flop in one of two modes. At 0 each flip-flop takes its chain predecessor, or the chain's serial input at position 0. At 1 each flip-flop takes the output of the network.

A pulse on `start` begins a run. The first phase checks chain integrity: a repeating 0,0,1,1 stream of (longest chain + 4) bits is pushed through every chain. The second phase applies a computed list of combinational vectors. For each vector the controller shifts the state in, raises capture-enable for one clock while the vector's primary-input value is applied, then shifts the captured response out while the next state goes in. A last unload feeds zeros. Every bit that appears at a chain output is compared with the expected stream, except bits marked don't-care. Mismatches are counted, a sticky fail flag is kept, and a one-cycle done pulse ends the run.

A `defect_sel` input plants one of three fixed defects in the circuit, so that the controller's detection can be exercised.

Top module: `scan_test_seq`

## Requirements
- R1: After reset `busy`, `done`, `fail` and `scan_en` are 0 and `err_count` is 0.
- R2: `scan_en` is 1 for exactly one clock per vector, NVEC times per run, and it is never high while idle. With L the longest chain, vector v's capture is busy cycle (L+4) + L + v*(L+1), counting the first busy cycle as 0.
- R3: For the first L+4 busy cycles, every chain's serial input carries bit 1 of the cycle index, which gives the stream 0,0,1,1,0,0,...
- R4: While capture-enable is 0 the chains shift: in the flush phase, chain c's output at busy cycle k (with k at least its length Lc) equals the flush bit of cycle k-Lc.
- R5: A run keeps `busy` high for exactly (NVEC+2)*L + NVEC + 4 cycles.
- R6: A chain shorter than L receives 0 as padding in the first L-Lc cycles of each load, so that all chains finish loading in the same cycle.
- R7: During the final unload (the last L busy cycles), every serial input is 0.
- R8: On a defect-free circuit a run ends with `fail` = 0 and `err_count` = 0.
- R9: With `defect_sel` = 1 (flip-flop 0 captures the inverted network value), a run ends with `fail` = 1 and `err_count` > 0.
- R10: With `defect_sel` = 2 (the shift path into chain 0 position 1 is stuck at 0), a run ends with `fail` = 1.
- R11: Captured bits marked don't-care are not compared. The last flip-flop is don't-care in every vector, so `defect_sel` = 3 (that flip-flop captures an inverted value) still ends with `fail` = 0 and `err_count` = 0.
- R12: `fail` and `err_count` keep their values after a run, never decrease during a run, and are cleared only by the next accepted `start`.
- R13: A `start` pulse while `busy` is high is ignored, and the run length is unchanged.
- R14: `done` is a single-cycle pulse, in the first cycle after `busy` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a run when idle |
| defect_sel | input | 2 | 0 none, 1 inverted capture at flip-flop 0, 2 broken shift into chain 0 position 1, 3 inverted capture at the last flip-flop |
| scan_en | output | 1 | Capture-enable line seen by every flip-flop (1 = capture) |
| chain_si | output | NCHAIN | Serial input of each chain |
| chain_so | output | NCHAIN | Serial output of each chain |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| fail | output | 1 | Sticky: some compared bit mismatched |
| err_count | output | ERRW | Saturating count of mismatching bits |

## Verification
A wrong phase or shift counter shows at the ports within one cycle: `scan_en` rises in a cycle other than the predicted capture slot, the serial inputs stop following the flush or padding stream, or `busy` falls on a cycle other than the one the closed formula predicts. A wrong vector index or wrong compare alignment shows only at the end of the run, as `fail` set on a good circuit or left clear under an injected defect. The three defect modes split this end-of-run evidence into a capture defect, a chain defect and a masked defect. A break in the chain also shows during the flush itself, as serial outputs that no longer repeat the delayed input stream.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_FLUSH,
        PH_LOAD,
        PH_CAPT,
        PH_SHIFT,
        PH_UNLOAD
    } phase_e;

    localparam int MAXW = 64;

    localparam logic [1:0] DEF_NONE   = 2'd0;
    localparam logic [1:0] DEF_CAPT0  = 2'd1;
    localparam logic [1:0] DEF_BREAK  = 2'd2;
    localparam logic [1:0] DEF_MASKED = 2'd3;

    // flip-flops are dealt round-robin, so lower chain indices get the extra one
    function automatic int chain_len(int nsff, int nchain, int c);
        return (nsff - c + nchain - 1) / nchain;
    endfunction

    function automatic logic state_bit(int v, int g);
        int t;
        t = (v + 1) * 13 + g * 7;
        return t[2];
    endfunction

    function automatic logic pi_bit(int v, int p);
        int t;
        t = (v + 2) * 11 + p * 5;
        return t[1];
    endfunction

    // the last flip-flop is never compared, and a sliding set of others is masked per vector
    function automatic logic care_bit(int v, int g, int nsff);
        return (g != nsff - 1) && (((v + g) % 4) != 3);
    endfunction

    // stand-in combinational network feeding the functional input of flip-flop g
    function automatic logic net_bit(logic [MAXW-1:0] s, logic [MAXW-1:0] x,
                                     int g, int nsff, int npi);
        logic b;
        b = s[(g + 1) % nsff] ^ (s[g] & x[g % npi]);
        if (g == 0) b = b ^ x[npi - 1];
        return b;
    endfunction

    function automatic logic flush_bit(int k);
        int t;
        t = k;
        return t[1];
    endfunction

endpackage

// File: rtl/scan_seq_stim.sv
module scan_seq_stim
    import scan_seq_pkg::*;
#(
    parameter int NSFF = 7,
    parameter int NPI  = 3,
    parameter int VW   = 3
) (
    input  logic [VW-1:0]   idx,
    output logic [NSFF-1:0] st,
    output logic [NSFF-1:0] exp_rsp,
    output logic [NSFF-1:0] care,
    output logic [NPI-1:0]  pv
);

    genvar g;
    genvar p;

    generate
        for (g = 0; g < NSFF; g++) begin : g_state
            assign st[g]   = state_bit(int'(idx), g);
            assign care[g] = care_bit(int'(idx), g, NSFF);
        end
        for (p = 0; p < NPI; p++) begin : g_pi
            assign pv[p] = pi_bit(int'(idx), p);
        end
        for (g = 0; g < NSFF; g++) begin : g_exp
            assign exp_rsp[g] = net_bit(MAXW'(st), MAXW'(pv), g, NSFF, NPI);
        end
    endgenerate

endmodule

// File: rtl/scan_seq_chains.sv
module scan_seq_chains
    import scan_seq_pkg::*;
#(
    parameter int NSFF   = 7,
    parameter int NCHAIN = 2,
    parameter int NPI    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tc,
    input  logic [NCHAIN-1:0] si,
    input  logic [NPI-1:0]    pi,
    input  logic [1:0]        defect_sel,
    output logic [NCHAIN-1:0] so
);

    logic [NSFF-1:0]        q_d;
    logic [NSFF-1:0]        q_q;
    logic [NSFF+NCHAIN-1:0] shift_src;

    // predecessor of flip-flop g is g-NCHAIN, or the chain input for position 0
    assign shift_src = {q_q, si};

    always_comb begin
        for (int g = 0; g < NSFF; g++) begin
            if (tc) begin
                q_d[g] = net_bit(MAXW'(q_q), MAXW'(pi), g, NSFF, NPI);
                if (g == 0 && defect_sel == DEF_CAPT0)
                    q_d[g] = ~q_d[g];
                if (g == NSFF - 1 && defect_sel == DEF_MASKED)
                    q_d[g] = ~q_d[g];
            end else begin
                q_d[g] = shift_src[g];
                if (g == NCHAIN && defect_sel == DEF_BREAK)
                    q_d[g] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    genvar c;
    generate
        for (c = 0; c < NCHAIN; c++) begin : g_tail
            localparam int LC = chain_len(NSFF, NCHAIN, c);
            assign so[c] = q_q[(LC - 1) * NCHAIN + c];
        end
    endgenerate

endmodule

// File: rtl/scan_seq_ctrl.sv
module scan_seq_ctrl
    import scan_seq_pkg::*;
#(
    parameter int NSFF   = 7,
    parameter int NCHAIN = 2,
    parameter int NPI    = 3,
    parameter int NVEC   = 4,
    parameter int ERRW   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [NCHAIN-1:0] so,
    output logic              tc,
    output logic [NCHAIN-1:0] si,
    output logic [NPI-1:0]    pi,
    output logic              busy,
    output logic              done,
    output logic              fail,
    output logic [ERRW-1:0]   err_count
);

    localparam int CHL    = chain_len(NSFF, NCHAIN, 0);
    localparam int FLUSHN = CHL + 4;
    localparam int KW     = $clog2(FLUSHN + 1);
    localparam int VW     = $clog2(NVEC + 1);

    typedef struct packed {
        phase_e          ph;
        logic [KW-1:0]   k;
        logic [VW-1:0]   v;
        logic            done;
        logic            fail;
        logic [ERRW-1:0] err;
    } seq_t;

    seq_t r_d;
    seq_t r_q;

    logic [VW-1:0]     rsp_idx;
    logic [NSFF-1:0]   ld_st;
    logic [NSFF-1:0]   ld_exp;
    logic [NSFF-1:0]   ld_care;
    logic [NSFF-1:0]   rsp_st;
    logic [NSFF-1:0]   rsp_exp;
    logic [NSFF-1:0]   rsp_care;
    logic [NPI-1:0]    rsp_pi;
    logic [NCHAIN-1:0] miss;
    logic [ERRW:0]     err_sum;
    logic              flushing;
    logic              loading;
    logic              unloading;
    int                kk;

    assign rsp_idx = r_q.v - 1'b1;

    scan_seq_stim #(.NSFF(NSFF), .NPI(NPI), .VW(VW)) u_ld (
        .idx     (r_q.v),
        .st      (ld_st),
        .exp_rsp (ld_exp),
        .care    (ld_care),
        .pv      (pi)
    );

    scan_seq_stim #(.NSFF(NSFF), .NPI(NPI), .VW(VW)) u_rsp (
        .idx     (rsp_idx),
        .st      (rsp_st),
        .exp_rsp (rsp_exp),
        .care    (rsp_care),
        .pv      (rsp_pi)
    );

    // serial stream and compare, per chain
    always_comb begin
        flushing  = (r_q.ph == PH_FLUSH);
        loading   = (r_q.ph == PH_LOAD) || (r_q.ph == PH_SHIFT);
        unloading = (r_q.ph == PH_SHIFT) || (r_q.ph == PH_UNLOAD);
        kk        = int'(r_q.k);
        si        = '0;
        miss      = '0;
        for (int c = 0; c < NCHAIN; c++) begin
            int lc;
            int jl;
            int g;
            lc = chain_len(NSFF, NCHAIN, c);
            jl = CHL - 1 - kk;
            g  = 0;
            if (flushing) begin
                si[c] = flush_bit(kk);
                if (kk >= lc && so[c] != flush_bit(kk - lc))
                    miss[c] = 1'b1;
            end
            if (loading && jl < lc)
                si[c] = ld_st[jl * NCHAIN + c];
            if (unloading && kk < lc) begin
                g = (lc - 1 - kk) * NCHAIN + c;
                if (rsp_care[g] && so[c] != rsp_exp[g])
                    miss[c] = 1'b1;
            end
        end
    end

    // phase sequencing
    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        tc       = 1'b0;
        err_sum  = {1'b0, r_q.err} + (ERRW + 1)'($countones(miss));
        if (|miss) begin
            r_d.fail = 1'b1;
            r_d.err  = err_sum[ERRW] ? '1 : err_sum[ERRW-1:0];
        end
        unique case (r_q.ph)
            PH_IDLE: begin
                if (start) begin
                    r_d.ph   = PH_FLUSH;
                    r_d.k    = '0;
                    r_d.v    = '0;
                    r_d.err  = '0;
                    r_d.fail = 1'b0;
                end
            end
            PH_FLUSH: begin
                if (r_q.k == KW'(FLUSHN - 1)) begin
                    r_d.ph = PH_LOAD;
                    r_d.k  = '0;
                end else begin
                    r_d.k = r_q.k + 1'b1;
                end
            end
            PH_LOAD, PH_SHIFT: begin
                if (r_q.k == KW'(CHL - 1)) begin
                    r_d.ph = PH_CAPT;
                    r_d.k  = '0;
                end else begin
                    r_d.k = r_q.k + 1'b1;
                end
            end
            PH_CAPT: begin
                tc    = 1'b1;
                r_d.v = r_q.v + 1'b1;
                r_d.ph = (r_q.v == VW'(NVEC - 1)) ? PH_UNLOAD : PH_SHIFT;
            end
            PH_UNLOAD: begin
                if (r_q.k == KW'(CHL - 1)) begin
                    r_d.ph   = PH_IDLE;
                    r_d.k    = '0;
                    r_d.done = 1'b1;
                end else begin
                    r_d.k = r_q.k + 1'b1;
                end
            end
            default: r_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.ph   <= PH_IDLE;
            r_q.k    <= '0;
            r_q.v    <= '0;
            r_q.done <= 1'b0;
            r_q.fail <= 1'b0;
            r_q.err  <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy      = (r_q.ph != PH_IDLE);
    assign done      = r_q.done;
    assign fail      = r_q.fail;
    assign err_count = r_q.err;

endmodule

// File: rtl/scan_test_seq.sv
module scan_test_seq
    import scan_seq_pkg::*;
#(
    parameter int NSFF   = 7,
    parameter int NCHAIN = 2,
    parameter int NPI    = 3,
    parameter int NVEC   = 4,
    parameter int ERRW   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        defect_sel,
    output logic              scan_en,
    output logic [NCHAIN-1:0] chain_si,
    output logic [NCHAIN-1:0] chain_so,
    output logic              busy,
    output logic              done,
    output logic              fail,
    output logic [ERRW-1:0]   err_count
);

    logic [NPI-1:0] pi_w;

    scan_seq_ctrl #(
        .NSFF(NSFF), .NCHAIN(NCHAIN), .NPI(NPI), .NVEC(NVEC), .ERRW(ERRW)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .so        (chain_so),
        .tc        (scan_en),
        .si        (chain_si),
        .pi        (pi_w),
        .busy      (busy),
        .done      (done),
        .fail      (fail),
        .err_count (err_count)
    );

    scan_seq_chains #(
        .NSFF(NSFF), .NCHAIN(NCHAIN), .NPI(NPI)
    ) u_cut (
        .clk        (clk),
        .rst_n      (rst_n),
        .tc         (scan_en),
        .si         (chain_si),
        .pi         (pi_w),
        .defect_sel (defect_sel),
        .so         (chain_so)
    );

endmodule

// File: rtl/scan_test_seq_chk.sv
module scan_test_seq_chk #(
    parameter int ERRW = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            scan_en,
    input logic            busy,
    input logic            done,
    input logic            fail,
    input logic [ERRW-1:0] err_count
);

    AST_CAPTURE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        scan_en |=> !scan_en); // R2

    AST_IDLE_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !scan_en); // R2

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R14

    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy))); // R14

    AST_ERR_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (err_count >= $past(err_count))); // R12

    AST_FAIL_TRACKS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        fail == (err_count != '0)); // R8

endmodule

bind scan_test_seq scan_test_seq_chk #(.ERRW(ERRW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scan_en   (scan_en),
    .busy      (busy),
    .done      (done),
    .fail      (fail),
    .err_count (err_count)
);

// File: tb/sim_scan_test_seq.sv
`timescale 1ns/1ps
module sim_scan_test_seq;

    localparam int NSFF   = 7;
    localparam int NCHAIN = 2;
    localparam int NVEC   = 4;
    localparam int ERRW   = 8;
    localparam int L      = 4;
    localparam int L1     = 3;
    localparam int FL     = L + 4;
    localparam int TOTAL  = (NVEC + 2) * L + NVEC + 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [1:0]        defect_sel = 2'd0;
    logic              scan_en;
    logic [NCHAIN-1:0] chain_si;
    logic [NCHAIN-1:0] chain_so;
    logic              busy;
    logic              done;
    logic              fail;
    logic [ERRW-1:0]   err_count;

    int checks = 0;
    int failures = 0;
    int busy_len;
    logic done_at_end;
    logic done_after;
    logic              en_s [64];
    logic [NCHAIN-1:0] si_s [64];
    logic [NCHAIN-1:0] so_s [64];

    always #5 clk = ~clk;

    scan_test_seq #(.NSFF(NSFF), .NCHAIN(NCHAIN), .NVEC(NVEC), .ERRW(ERRW)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .defect_sel(defect_sel),
        .scan_en(scan_en), .chain_si(chain_si), .chain_so(chain_so),
        .busy(busy), .done(done), .fail(fail), .err_count(err_count)
    );

    task automatic chk(input logic ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    function automatic logic pat(int k);
        return logic'((k >> 1) & 1);
    endfunction

    task automatic run_seq(input logic [1:0] dsel, input logic poke);
        @(negedge clk);
        defect_sel = dsel;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        busy_len = 0;
        while (busy && busy_len < 64) begin
            en_s[busy_len] = scan_en;
            si_s[busy_len] = chain_si;
            so_s[busy_len] = chain_so;
            start = (poke && busy_len == 5);
            busy_len++;
            @(negedge clk);
        end
        start = 1'b0;
        done_at_end = done;
        @(negedge clk);
        done_after = done;
    endtask

    task automatic t_reset();
        chk(!busy && !done && !fail && !scan_en, "R1 idle flags", {busy, done, fail, scan_en}, 0);
        chk(err_count == 0, "R1 err_count", err_count, 0);
    endtask

    task automatic t_good();
        int bad;
        run_seq(2'd0, 1'b0);
        chk(busy_len == TOTAL, "R5 run length", busy_len, TOTAL);
        chk(done_at_end == 1'b1, "R14 done after busy", done_at_end, 1);
        chk(done_after == 1'b0, "R14 done one cycle", done_after, 0);
        bad = 0;
        for (int i = 0; i < TOTAL; i++) begin
            logic e;
            e = 1'b0;
            for (int v = 0; v < NVEC; v++)
                if (i == FL + L + v * (L + 1)) e = 1'b1;
            if (en_s[i] != e) bad++;
        end
        chk(bad == 0, "R2 capture slots", bad, 0);
        bad = 0;
        for (int i = 0; i < FL; i++)
            for (int c = 0; c < NCHAIN; c++)
                if (si_s[i][c] != pat(i)) bad++;
        chk(bad == 0, "R3 flush stream", bad, 0);
        bad = 0;
        for (int i = L; i < FL; i++)
            if (so_s[i][0] != pat(i - L)) bad++;
        for (int i = L1; i < FL; i++)
            if (so_s[i][1] != pat(i - L1)) bad++;
        chk(bad == 0, "R4 flush shift-through", bad, 0);
        bad = 0;
        for (int v = 0; v < NVEC; v++)
            if (si_s[FL + v * (L + 1)][1] != 1'b0) bad++;
        chk(bad == 0, "R6 short chain padding", bad, 0);
        bad = 0;
        for (int i = TOTAL - L; i < TOTAL; i++)
            if (si_s[i] != '0) bad++;
        chk(bad == 0, "R7 final unload zeros", bad, 0);
        chk(fail == 1'b0, "R8 fail clear", fail, 0);
        chk(err_count == 0, "R8 err_count zero", err_count, 0);
    endtask

    task automatic t_capture_defect();
        run_seq(2'd1, 1'b0);
        chk(fail == 1'b1, "R9 fail set", fail, 1);
        chk(err_count > 0, "R9 err_count nonzero", err_count, 1);
        repeat (3) @(negedge clk);
        chk(fail == 1'b1, "R12 fail sticky", fail, 1);
    endtask

    task automatic t_clear_on_start();
        run_seq(2'd0, 1'b0);
        chk(fail == 1'b0 && err_count == 0, "R12 cleared by start", err_count, 0);
    endtask

    task automatic t_chain_break();
        run_seq(2'd2, 1'b0);
        chk(fail == 1'b1, "R10 chain break detected", fail, 1);
    endtask

    task automatic t_masked();
        run_seq(2'd3, 1'b0);
        chk(fail == 1'b0, "R11 masked defect no fail", fail, 0);
        chk(err_count == 0, "R11 masked defect no count", err_count, 0);
    endtask

    task automatic t_busy_start();
        run_seq(2'd0, 1'b1);
        chk(busy_len == TOTAL, "R13 start while busy ignored", busy_len, TOTAL);
        chk(fail == 1'b0, "R13 result unchanged", fail, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_good();
        t_capture_defect();
        t_clear_on_start();
        t_chain_break();
        t_masked();
        t_busy_start();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #200000;
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule